// File: doc/BRIEF.md
# Multi-Port Memory Protection Unit

This block decides, for several bus access ports at once, whether each access may proceed. It holds a table of programmable protection regions. Each region has an inclusive block-aligned address window, a valid flag, an optional process-ID filter, and a set of rights for every bus master. An access is allowed when at least one valid region covers its address, passes the process-ID filter, and grants the requested kind of access to the requesting master in its current privilege mode. Regions may overlap, and the rights of all matching regions are combined as a union.

Software loads the table through a write-only configuration port. One write updates one field of one region. Each access port presents a request and receives a registered verdict one cycle later. When an access is denied, the port also raises an error and records a syndrome (address, master and kind). The syndrome holds its value until the next denial on that same port.

Top module: `mpu_top`

## Requirements
- R1: After reset no region is valid, every requested access is denied with an error, and every syndrome output reads zero.
- R2: A region matches only when its valid bit (control word bit 0) is set and lo <= addr[31:5] <= hi; both bounds are inclusive and taken from cfg_wdata[31:5]; address bits [4:0] never affect the verdict.
- R3: When several matching regions cover an address, the access is allowed if any one of them grants the requested right.
- R4: Each master m owns rights bits [6m+5:6m]. For non-processor masters (2 and 3), bit 6m grants read and bit 6m+1 grants write. An execute request from these masters is always denied, and req_super has no effect on them.
- R5: For processor masters (0 and 1), bits 6m+0/1/2 grant supervisor read/write/execute and bits 6m+3/4/5 grant user read/write/execute; req_super selects the set.
- R6: When control word bit 1 is set, a region matches only if req_pid equals the region ID (control bits [15:8]) on every bit whose mask bit (control bits [23:16]) is zero; bits with a mask bit of one are ignored.
- R7: The four ports are evaluated independently in the same cycle. A request at one clock edge produces rsp_valid at the next edge, together with exactly one of rsp_allow or rsp_err.
- R8: A configuration write (cfg_field 0 = lo, 1 = hi, 2 = control, 3 = rights from cfg_wdata[23:0]) takes effect for requests presented in the following cycle; a request presented in the same cycle as the write sees the old descriptor.
- R9: On a denial, the port's syndrome captures the request address, the master and the kind. It keeps that value, unchanged, until the port's next denial.
- R10: Access kind encoding is 0 = read, 1 = write, 2 = execute; kind 3 is always denied.
- R11: A port with no request in a cycle returns rsp_valid, rsp_allow and rsp_err all low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 4 | Region index written |
| cfg_field | input | 2 | Field selector: 0 lo, 1 hi, 2 control, 3 rights |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 4 | Request present, one bit per port |
| req_addr | input | 4x32 | Access address per port |
| req_master | input | 4x2 | Requesting master number per port |
| req_kind | input | 4x2 | Access kind per port |
| req_super | input | 4 | Supervisor mode per port |
| req_pid | input | 4x8 | Current process ID per port |
| rsp_valid | output | 4 | Verdict present |
| rsp_allow | output | 4 | Access allowed |
| rsp_err | output | 4 | Access denied |
| syn_addr | output | 4x32 | Address of the last denied access |
| syn_master | output | 4x2 | Master of the last denied access |
| syn_kind | output | 4x2 | Kind of the last denied access |

## Verification
On every cycle the assertions check the verdict timing: a verdict follows each request one cycle later, and no verdict appears without a request. They also check that allow and error are mutually exclusive, that reserved kinds are refused, and that the syndrome both captures the denied request and stays still between denials. Whether a verdict is the correct one depends on region bounds, overlaps, per-master rights, privilege and process-ID filtering. Only the bench's sweeps can show this, because they compare every port against an arithmetic model over boundary addresses and every master, kind and mode. The bench also covers the write-then-check ordering of R8 in a dedicated scenario.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int ADDR_W      = 32;
    localparam int GRAN_BITS   = 5;
    localparam int BLK_W       = ADDR_W - GRAN_BITS;
    localparam int PID_W       = 8;
    localparam int NUM_MASTERS = 4;
    localparam int NUM_CPU     = 2;
    localparam int MID_W       = $clog2(NUM_MASTERS);
    localparam int RIGHT_BITS  = 6;
    localparam int RIGHTS_W    = NUM_MASTERS * RIGHT_BITS;
    localparam int CFG_W       = 32;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        FLD_LO     = 2'd0,
        FLD_HI     = 2'd1,
        FLD_CTRL   = 2'd2,
        FLD_RIGHTS = 2'd3
    } field_e;

    typedef struct packed {
        logic [BLK_W-1:0]    lo;
        logic [BLK_W-1:0]    hi;
        logic                valid;
        logic                pid_en;
        logic [PID_W-1:0]    pid;
        logic [PID_W-1:0]    pid_mask;
        logic [RIGHTS_W-1:0] rights;
    } region_t;

    typedef struct packed {
        logic              vld;
        logic              ok;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  mst;
        logic [1:0]        kind;
    } verdict_t;

    // Rights lookup: processor masters pick a supervisor or user triple,
    // other masters only have read and write.
    function automatic logic right_ok(logic [RIGHTS_W-1:0] r, logic [MID_W-1:0] m,
                                      logic [1:0] k, logic sup);
        logic [RIGHT_BITS-1:0] g;
        g = r[int'(m)*RIGHT_BITS +: RIGHT_BITS];
        if (k == KIND_RSVD) return 1'b0;
        if (int'(m) < NUM_CPU) return sup ? g[int'(k)] : g[3 + int'(k)];
        if (k == KIND_EXEC) return 1'b0;
        return g[int'(k)];
    endfunction
endpackage

// File: rtl/mpu_region_table.sv
module mpu_region_table
    import mpu_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [1:0]                 field_i,
    input  logic [CFG_W-1:0]           wdata_i,
    output region_t [NREG-1:0]         table_o
);
    region_t [NREG-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we_i) begin
            unique case (field_e'(field_i))
                FLD_LO:     tbl_d[idx_i].lo = wdata_i[ADDR_W-1:GRAN_BITS];
                FLD_HI:     tbl_d[idx_i].hi = wdata_i[ADDR_W-1:GRAN_BITS];
                FLD_CTRL: begin
                    tbl_d[idx_i].valid    = wdata_i[0];
                    tbl_d[idx_i].pid_en   = wdata_i[1];
                    tbl_d[idx_i].pid      = wdata_i[8 +: PID_W];
                    tbl_d[idx_i].pid_mask = wdata_i[16 +: PID_W];
                end
                FLD_RIGHTS: tbl_d[idx_i].rights = wdata_i[RIGHTS_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) tbl_q[r] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign table_o = tbl_q;
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int NREG = 16
) (
    input  region_t [NREG-1:0] table_i,
    input  logic [BLK_W-1:0]   blk_i,
    input  logic [MID_W-1:0]   mst_i,
    input  logic [1:0]         kind_i,
    input  logic               sup_i,
    input  logic [PID_W-1:0]   pid_i,
    output logic               granted_o
);
    logic [NREG-1:0] grant;

    for (genvar r = 0; r < NREG; r++) begin : g_region
        logic in_win, pid_ok;
        assign in_win = table_i[r].valid
                     && (blk_i >= table_i[r].lo) && (blk_i <= table_i[r].hi);
        assign pid_ok = !table_i[r].pid_en
                     || (((pid_i ^ table_i[r].pid) & ~table_i[r].pid_mask) == '0);
        assign grant[r] = in_win && pid_ok
                       && right_ok(table_i[r].rights, mst_i, kind_i, sup_i);
    end

    assign granted_o = |grant;
endmodule

// File: rtl/mpu_port_result.sv
module mpu_port_result
    import mpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              granted_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MID_W-1:0]  mst_i,
    input  logic [1:0]        kind_i,
    output verdict_t          verdict_o
);
    verdict_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_i;
        st_d.ok  = req_i && granted_i;
        st_d.err = req_i && !granted_i;
        if (req_i && !granted_i) begin
            st_d.addr = addr_i;
            st_d.mst  = mst_i;
            st_d.kind = kind_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign verdict_o = st_q;
endmodule

// File: rtl/mpu_top.sv
module mpu_top
    import mpu_pkg::*;
#(
    parameter int NP   = 4,
    parameter int NREG = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_region,
    input  logic [1:0]                   cfg_field,
    input  logic [CFG_W-1:0]             cfg_wdata,
    input  logic [NP-1:0]                req_valid,
    input  logic [NP-1:0][ADDR_W-1:0]    req_addr,
    input  logic [NP-1:0][MID_W-1:0]     req_master,
    input  logic [NP-1:0][1:0]           req_kind,
    input  logic [NP-1:0]                req_super,
    input  logic [NP-1:0][PID_W-1:0]     req_pid,
    output logic [NP-1:0]                rsp_valid,
    output logic [NP-1:0]                rsp_allow,
    output logic [NP-1:0]                rsp_err,
    output logic [NP-1:0][ADDR_W-1:0]    syn_addr,
    output logic [NP-1:0][MID_W-1:0]     syn_master,
    output logic [NP-1:0][1:0]           syn_kind
);
    region_t [NREG-1:0] tbl;

    mpu_region_table #(.NREG(NREG)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .idx_i   (cfg_region),
        .field_i (cfg_field),
        .wdata_i (cfg_wdata),
        .table_o (tbl)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic     granted;
        verdict_t vd;

        mpu_region_match #(.NREG(NREG)) u_match (
            .table_i   (tbl),
            .blk_i     (req_addr[p][ADDR_W-1:GRAN_BITS]),
            .mst_i     (req_master[p]),
            .kind_i    (req_kind[p]),
            .sup_i     (req_super[p]),
            .pid_i     (req_pid[p]),
            .granted_o (granted)
        );

        mpu_port_result u_result (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_valid[p]),
            .granted_i (granted),
            .addr_i    (req_addr[p]),
            .mst_i     (req_master[p]),
            .kind_i    (req_kind[p]),
            .verdict_o (vd)
        );

        assign rsp_valid[p]  = vd.vld;
        assign rsp_allow[p]  = vd.ok;
        assign rsp_err[p]    = vd.err;
        assign syn_addr[p]   = vd.addr;
        assign syn_master[p] = vd.mst;
        assign syn_kind[p]   = vd.kind;
    end
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
    import mpu_pkg::*;
#(
    parameter int NP   = 4,
    parameter int NREG = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [IDX_W-1:0]          cfg_region,
    input logic [1:0]                cfg_field,
    input logic [CFG_W-1:0]          cfg_wdata,
    input logic [NP-1:0]             req_valid,
    input logic [NP-1:0][ADDR_W-1:0] req_addr,
    input logic [NP-1:0][MID_W-1:0]  req_master,
    input logic [NP-1:0][1:0]        req_kind,
    input logic [NP-1:0]             req_super,
    input logic [NP-1:0][PID_W-1:0]  req_pid,
    input logic [NP-1:0]             rsp_valid,
    input logic [NP-1:0]             rsp_allow,
    input logic [NP-1:0]             rsp_err,
    input logic [NP-1:0][ADDR_W-1:0] syn_addr,
    input logic [NP-1:0][MID_W-1:0]  syn_master,
    input logic [NP-1:0][1:0]        syn_kind
);
    for (genvar p = 0; p < NP; p++) begin : g_chk
        assert_req_gives_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[p] |=> rsp_valid[p]);

        assert_idle_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[p] |=> (!rsp_valid[p] && !rsp_err[p] && !rsp_allow[p]));

        assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[p] |-> $onehot({rsp_allow[p], rsp_err[p]}));

        assert_rsvd_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_kind[p] == 2'd3) |=> (rsp_err[p] && !rsp_allow[p]));

        assert_syn_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_kind[p] == 2'd3) |=>
                (syn_addr[p] == $past(req_addr[p]) && syn_master[p] == $past(req_master[p])
                 && syn_kind[p] == 2'd3));

        assert_syn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_err[p] |-> ($stable(syn_addr[p]) && $stable(syn_master[p])
                             && $stable(syn_kind[p])));
    end
endmodule

bind mpu_top mpu_checker #(.NP(NP), .NREG(NREG)) u_chk (.*);

// File: tb/mpu_top_tb.sv
module mpu_top_tb;
    localparam int NP = 4;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_region = '0;
    logic [1:0] cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NP-1:0] req_valid = '0;
    logic [NP-1:0][31:0] req_addr = '0;
    logic [NP-1:0][1:0] req_master = '0;
    logic [NP-1:0][1:0] req_kind = '0;
    logic [NP-1:0] req_super = '0;
    logic [NP-1:0][7:0] req_pid = '0;
    logic [NP-1:0] rsp_valid, rsp_allow, rsp_err;
    logic [NP-1:0][31:0] syn_addr;
    logic [NP-1:0][1:0] syn_master, syn_kind;

    always #4 clk = ~clk;

    mpu_top #(.NP(NP), .NREG(NREG)) u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the table
    logic [26:0] m_lo [NREG];
    logic [26:0] m_hi [NREG];
    bit          m_vld [NREG];
    bit          m_pen [NREG];
    logic [7:0]  m_pid [NREG];
    logic [7:0]  m_msk [NREG];
    logic [23:0] m_rt [NREG];

    logic [31:0] e_saddr [NP];
    logic [1:0]  e_smst [NP];
    logic [1:0]  e_skind [NP];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_ok(logic [31:0] a, int m, int k, bit s, logic [7:0] pid);
        bit any = 0;
        for (int r = 0; r < NREG; r++) begin
            if (m_vld[r] && a[31:5] >= m_lo[r] && a[31:5] <= m_hi[r]
                && (!m_pen[r] || ((pid ^ m_pid[r]) & ~m_msk[r]) == 8'h00)) begin
                bit g;
                if (k == 3)      g = 0;
                else if (m < 2)  g = m_rt[r][6*m + (s ? 0 : 3) + k];
                else if (k == 2) g = 0;
                else             g = m_rt[r][6*m + k];
                any |= g;
            end
        end
        return any;
    endfunction

    task automatic model_write(int idx, int fld, logic [31:0] d);
        case (fld)
            0: m_lo[idx] = d[31:5];
            1: m_hi[idx] = d[31:5];
            2: begin m_vld[idx] = d[0]; m_pen[idx] = d[1];
                     m_pid[idx] = d[15:8]; m_msk[idx] = d[23:16]; end
            default: m_rt[idx] = d[23:0];
        endcase
    endtask

    task automatic cfg_write(int idx, int fld, logic [31:0] d);
        cfg_we = 1'b1; cfg_region = 4'(idx); cfg_field = 2'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(idx, fld, d);
    endtask

    // requests are already driven; compute expectation, cross one edge, compare
    task automatic run_cycle(string tag);
        bit ev [NP];
        bit eo [NP];
        for (int p = 0; p < NP; p++) begin
            ev[p] = req_valid[p];
            eo[p] = req_valid[p] && exp_ok(req_addr[p], int'(req_master[p]), int'(req_kind[p]),
                                           req_super[p], req_pid[p]);
            if (ev[p] && !eo[p]) begin
                e_saddr[p] = req_addr[p]; e_smst[p] = req_master[p]; e_skind[p] = req_kind[p];
            end
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk({tag, " R7 valid"}, 64'(rsp_valid[p]), 64'(ev[p]));
            chk({tag, " allow"}, 64'(rsp_allow[p]), 64'(eo[p]));
            chk({tag, " err"}, 64'(rsp_err[p]), 64'(ev[p] && !eo[p]));
            chk({tag, " R9 syn_addr"}, 64'(syn_addr[p]), 64'(e_saddr[p]));
            chk({tag, " R9 syn_master"}, 64'(syn_master[p]), 64'(e_smst[p]));
            chk({tag, " R9 syn_kind"}, 64'(syn_kind[p]), 64'(e_skind[p]));
        end
    endtask

    function automatic logic [31:0] addr_pt(int i);
        case (i)
            0: return 32'h0000_0FE0;  1: return 32'h0000_0FFF;
            2: return 32'h0000_1000;  3: return 32'h0000_101F;
            4: return 32'h0000_17E0;  5: return 32'h0000_1800;
            6: return 32'h0000_1FFF;  7: return 32'h0000_2000;
            8: return 32'h0000_27FF;  9: return 32'h0000_2800;
            10: return 32'h0000_2FFF; 11: return 32'h0000_3000;
            12: return 32'h0000_30FF; 13: return 32'h0000_3100;
            14: return 32'h0000_7FFF; 15: return 32'h0000_8000;
            16: return 32'h0000_801F; 17: return 32'h0000_8020;
            18: return 32'hFFFF_FFFF; default: return 32'h0000_0000;
        endcase
    endfunction

    task automatic sweep(string tag, int n_addr);
        for (int i = 0; i < n_addr; i++)
            for (int c = 0; c < 32; c++)
                for (int v = 0; v < 2; v++) begin
                    for (int p = 0; p < NP; p++) begin
                        int cb = (c + 8*p) % 32;
                        req_valid[p]  = !(p == 3 && (c % 7) == 6);
                        req_addr[p]   = addr_pt(i);
                        req_master[p] = 2'(cb);
                        req_kind[p]   = 2'(cb >> 2);
                        req_super[p]  = cb[4];
                        req_pid[p]    = v ? 8'hA5 : 8'h53;
                    end
                    run_cycle(tag);
                end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin
            m_lo[r] = '0; m_hi[r] = '0; m_vld[r] = 0; m_pen[r] = 0;
            m_pid[r] = '0; m_msk[r] = '0; m_rt[r] = '0;
        end
        for (int p = 0; p < NP; p++) begin
            e_saddr[p] = '0; e_smst[p] = '0; e_skind[p] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            chk("R1 reset rsp_valid", 64'(rsp_valid[p]), 64'd0);
            chk("R1 reset syn_addr", 64'(syn_addr[p]), 64'd0);
        end
        rst_n = 1'b1;
        // R11: idle ports
        run_cycle("R11 idle");
        // R1: empty table denies everything (R10 kinds swept too)
        sweep("R1 empty", 4);

        // region 0: 0x1000..0x1FFF, m0 supervisor rwx, m2 read
        cfg_write(0, 0, 32'h0000_1000); cfg_write(0, 1, 32'h0000_1FE0);
        cfg_write(0, 3, 32'h0000_1007); cfg_write(0, 2, 32'h0000_0001);
        // region 1 overlaps: 0x1800..0x27FF, m0 user read, m2 write, m3 rw
        cfg_write(1, 0, 32'h0000_1800); cfg_write(1, 1, 32'h0000_27E0);
        cfg_write(1, 3, 32'h000C_2008); cfg_write(1, 2, 32'h0000_0001);
        // region 2: 0x3000..0x30FF, PID 0x5A mask 0x0F, all rights
        cfg_write(2, 0, 32'h0000_3000); cfg_write(2, 1, 32'h0000_30E0);
        cfg_write(2, 3, 32'h00FF_FFFF); cfg_write(2, 2, 32'h000F_5A03);
        // region 15: single block 0x8000, m1 user execute
        cfg_write(15, 0, 32'h0000_8000); cfg_write(15, 1, 32'h0000_8000);
        cfg_write(15, 3, 32'h0000_0800); cfg_write(15, 2, 32'h0000_0001);

        // R2 R3 R4 R5 R6 R7 R9 R10: boundary sweep over all masters, kinds, modes
        sweep("R2-sweep R3 R4 R5 R6", 20);

        // R8: write in the same cycle as a check
        cfg_write(3, 0, 32'h0000_9000); cfg_write(3, 1, 32'h0000_9000);
        cfg_write(3, 3, 32'h00FF_FFFF);
        req_valid = '0;
        req_valid[0] = 1'b1; req_addr[0] = 32'h0000_9004;
        req_master[0] = 2'd0; req_kind[0] = 2'd0; req_super[0] = 1'b1;
        cfg_we = 1'b1; cfg_region = 4'd3; cfg_field = 2'd2; cfg_wdata = 32'h1;
        run_cycle("R8 same cycle old");
        chk("R8 same cycle denied", 64'(rsp_err[0]), 64'd1);
        cfg_we = 1'b0;
        model_write(3, 2, 32'h1);
        run_cycle("R8 next cycle new");
        chk("R8 next cycle allowed", 64'(rsp_allow[0]), 64'd1);

        // R3: drop region 0, overlap area still served by region 1 only
        cfg_write(0, 2, 32'h0000_0000);
        sweep("R3 after invalidate", 10);

        req_valid = '0;
        run_cycle("R11 final idle");
        finish_run();
    end
endmodule